// File: doc/BRIEF.md
# BF16 Vector Exponent-Scale Unit

This unit applies a power-of-two scale to every BFloat16 lane of a group of two or four consecutive vector registers. Each lane is multiplied by two raised to a signed 16-bit integer. The integer comes from the lane in the same position of a single scale register, and that register serves the whole group. The results replace the group's original contents.

An issue request carries three fields: a group field, a 4-bit scale-register field and a size select. The unit reads the scale register first. It then reads each group register and computes its scaled result into an internal buffer. Only after all group registers have been read does it write the results back, one register per cycle, in ascending index order. A one-cycle done pulse follows the last write. The unit reaches the register file through one combinational read port and one write port.

Two feature enables gate the operation. If either enable is low when a request is accepted, the unit raises a one-cycle undefined-instruction pulse and writes nothing.

Top module: `bf16_vscale_unit`

## Requirements
- R1: Lane i of a register occupies bits [16i+15:16i], with sign in bit 15, exponent in bits 14:7 and mantissa in bits 6:0. A normal lane with exponent e, scaled by the two's-complement value k of the scale lane, yields exponent e+k with sign and mantissa unchanged whenever 1 <= e+k <= 254.
- R2: A normal lane with e+k >= 255 becomes a signed infinity (exponent 255, mantissa 0). A normal lane with e+k <= 0 becomes a signed zero. An input lane with exponent 0 (zero or subnormal) becomes a signed zero. The extremes of k (-32768 and 32767) never wrap.
- R3: In pair form (size select 0), the group is registers 2g and 2g+1, where g is the 4-bit group field. In quad form (size select 1), the group is registers 4g' to 4g'+3, where g' is bits 2:0 of the group field; bit 3 is ignored.
- R4: The scale register index is the 4-bit scale field zero-extended, so only registers 0 to 15 can be selected. Lane i of that one register scales lane i of every group register.
- R5: Every result comes from the register values present at acceptance, even when the scale register lies inside the group.
- R6: A NaN lane (exponent 255, mantissa nonzero) is returned with mantissa bit 6 set and its other bits kept. An infinity lane is returned unchanged for any scale.
- R7: Every lane of every group register is written. No register outside the group is written.
- R8: A request accepted while either feature enable is low produces an undefined pulse in the next cycle and no register writes.
- R9: req_ready is high only while the unit is idle. done is high for exactly one cycle, the cycle right after the last write of an operation.
- R10: Group writes happen one per cycle, on consecutive cycles, in ascending register index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_a_en | input | 1 | First feature enable |
| feat_b_en | input | 1 | Second feature enable |
| req_valid | input | 1 | Issue request valid |
| req_ready | output | 1 | Unit idle and able to accept |
| req_quad | input | 1 | Size select: 0 = two registers, 1 = four registers |
| req_grp | input | 4 | Group field |
| req_scl | input | 4 | Scale-register field |
| rf_rd_idx | output | IDX_W | Register-file read index |
| rf_rd_data | input | VLEN | Register-file read data (same cycle) |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | IDX_W | Register-file write index |
| rf_wr_data | output | VLEN | Register-file write data |
| done | output | 1 | One-cycle pulse after the last write-back |
| undef | output | 1 | One-cycle undefined-instruction pulse |

## Verification
The bench builds the unit with VLEN = 128 (eight lanes per register) and 32 registers. With eight lanes, a single scale register can hold every scale case at once: ±1, ±200, both 16-bit extremes, a small positive scale and zero. A quad group at the top of the index space can use scale register 15. Because the register file is 32 entries, a group field with bit 3 set reaches a case where the quad form must drop that bit. A quad group that contains its own scale register exercises the read-before-write rule.

// File: rtl/bf16s_pkg.sv
package bf16s_pkg;
    localparam int LANE_W   = 16;
    localparam int EXP_SAT  = 300;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RSCL = 2'd1,
        ST_RGRP = 2'd2,
        ST_WR   = 2'd3
    } st_e;
endpackage

// File: rtl/bf16s_lane.sv
module bf16s_lane
    import bf16s_pkg::*;
(
    input  logic [LANE_W-1:0] val_i,
    input  logic [LANE_W-1:0] scl_i,
    output logic [LANE_W-1:0] res_o
);
    logic              sgn;
    logic [7:0]        ex;
    logic [6:0]        mt;
    logic signed [15:0] sc;
    logic signed [10:0] kc;
    logic signed [10:0] sum;

    always_comb begin
        sgn = val_i[15];
        ex  = val_i[14:7];
        mt  = val_i[6:0];
        sc  = signed'(scl_i);
        // saturate the scale so the exponent sum cannot wrap
        if (sc > 16'(EXP_SAT))
            kc = 11'(EXP_SAT);
        else if (sc < -16'(EXP_SAT))
            kc = -11'(EXP_SAT);
        else
            kc = sc[10:0];
        sum = signed'({3'b000, ex}) + kc;

        if (ex == 8'hFF)
            res_o = (mt != 7'd0) ? {sgn, 8'hFF, 1'b1, mt[5:0]} : val_i;
        else if (ex == 8'h00)
            res_o = {sgn, 15'd0};
        else if (sum >= 11'sd255)
            res_o = {sgn, 8'hFF, 7'd0};
        else if (sum <= 11'sd0)
            res_o = {sgn, 15'd0};
        else
            res_o = {sgn, sum[7:0], mt};
    end
endmodule

// File: rtl/bf16s_vec.sv
module bf16s_vec
    import bf16s_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic [VLEN-1:0] src_i,
    input  logic [VLEN-1:0] scl_i,
    output logic [VLEN-1:0] res_o
);
    localparam int LANES = VLEN / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bf16s_lane u_lane (
            .val_i (src_i[g*LANE_W +: LANE_W]),
            .scl_i (scl_i[g*LANE_W +: LANE_W]),
            .res_o (res_o[g*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/bf16_vscale_unit.sv
module bf16_vscale_unit
    import bf16s_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int REGS = 32,
    localparam int IDX_W = $clog2(REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feat_a_en,
    input  logic             feat_b_en,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_quad,
    input  logic [3:0]       req_grp,
    input  logic [3:0]       req_scl,
    output logic [IDX_W-1:0] rf_rd_idx,
    input  logic [VLEN-1:0]  rf_rd_data,
    output logic             rf_wr_en,
    output logic [IDX_W-1:0] rf_wr_idx,
    output logic [VLEN-1:0]  rf_wr_data,
    output logic             done,
    output logic             undef
);
    localparam int MAXG = 4;

    typedef struct packed {
        st_e                       st;
        logic [IDX_W-1:0]          base;
        logic [3:0]                sidx;
        logic                      quad;
        logic [1:0]                cnt;
        logic [VLEN-1:0]           scl;
        logic [MAXG-1:0][VLEN-1:0] res;
        logic                      done;
        logic                      undef;
    } ctx_t;

    ctx_t ctx_d, ctx_q;
    logic [VLEN-1:0] vec_res;
    logic            last;

    bf16s_vec #(.VLEN(VLEN)) u_vec (
        .src_i (rf_rd_data),
        .scl_i (ctx_q.scl),
        .res_o (vec_res)
    );

    always_comb begin
        ctx_d       = ctx_q;
        ctx_d.done  = 1'b0;
        ctx_d.undef = 1'b0;
        last        = (ctx_q.cnt == (ctx_q.quad ? 2'd3 : 2'd1));
        req_ready   = (ctx_q.st == ST_IDLE);
        rf_rd_idx   = '0;
        rf_wr_en    = 1'b0;
        rf_wr_idx   = ctx_q.base + IDX_W'(ctx_q.cnt);
        rf_wr_data  = ctx_q.res[ctx_q.cnt];

        case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (feat_a_en && feat_b_en) begin
                        ctx_d.st   = ST_RSCL;
                        ctx_d.base = req_quad ? IDX_W'({req_grp[2:0], 2'b00})
                                              : IDX_W'({req_grp, 1'b0});
                        ctx_d.sidx = req_scl;
                        ctx_d.quad = req_quad;
                        ctx_d.cnt  = 2'd0;
                    end else begin
                        ctx_d.undef = 1'b1;
                    end
                end
            end
            ST_RSCL: begin
                rf_rd_idx = IDX_W'(ctx_q.sidx);
                ctx_d.scl = rf_rd_data;
                ctx_d.st  = ST_RGRP;
            end
            ST_RGRP: begin
                rf_rd_idx              = ctx_q.base + IDX_W'(ctx_q.cnt);
                ctx_d.res[ctx_q.cnt]   = vec_res;
                ctx_d.cnt              = ctx_q.cnt + 2'd1;
                if (last) begin
                    ctx_d.cnt = 2'd0;
                    ctx_d.st  = ST_WR;
                end
            end
            ST_WR: begin
                rf_wr_en  = 1'b1;
                ctx_d.cnt = ctx_q.cnt + 2'd1;
                if (last) begin
                    ctx_d.cnt  = 2'd0;
                    ctx_d.st   = ST_IDLE;
                    ctx_d.done = 1'b1;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase

        done  = ctx_q.done;
        undef = ctx_q.undef;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end
endmodule

// File: rtl/bf16s_chk.sv
module bf16s_chk #(
    parameter int VLEN  = 128,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             feat_a_en,
    input logic             feat_b_en,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rf_wr_en,
    input logic [IDX_W-1:0] rf_wr_idx,
    input logic [VLEN-1:0]  rf_wr_data,
    input logic             done,
    input logic             undef
);
    localparam int LANES = VLEN / 16;

    assert_undef_nowr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !(feat_a_en && feat_b_en)) |=> (undef && !rf_wr_en));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rf_wr_en));

    assert_busy_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> !req_ready);

    assert_ascend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en && $past(rf_wr_en)) |-> (rf_wr_idx == $past(rf_wr_idx) + IDX_W'(1)));

    for (genvar g = 0; g < LANES; g++) begin : g_nan
        assert_nan_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rf_wr_en && rf_wr_data[g*16+7 +: 8] == 8'hFF && rf_wr_data[g*16 +: 7] != 7'd0)
            |-> rf_wr_data[g*16+6]);
    end
endmodule

bind bf16_vscale_unit bf16s_chk #(.VLEN(VLEN), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_bf16_vscale_unit.sv
module sim_bf16_vscale_unit;
    localparam int CLK_PERIOD = 10;
    localparam int VLEN  = 128;
    localparam int REGS  = 32;
    localparam int IDX_W = 5;
    localparam int LANES = VLEN / 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic feat_a_en = 1'b1, feat_b_en = 1'b1;
    logic req_valid = 1'b0, req_quad = 1'b0;
    logic [3:0] req_grp = '0, req_scl = '0;
    logic req_ready, rf_wr_en, done, undef;
    logic [IDX_W-1:0] rf_rd_idx, rf_wr_idx;
    logic [VLEN-1:0] rf_rd_data, rf_wr_data;

    logic [VLEN-1:0] rf [REGS];
    logic [VLEN-1:0] shadow [REGS];

    typedef struct { int idx; logic [VLEN-1:0] data; } wr_t;
    wr_t exp_q[$];

    int checks = 0, fails = 0;
    bit run_mon = 0, finished = 0, dexp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bf16_vscale_unit #(.VLEN(VLEN), .REGS(REGS)) u0 (.*);

    assign rf_rd_data = rf[rf_rd_idx];
    always @(posedge clk) if (rf_wr_en) rf[rf_wr_idx] <= rf_wr_data;

    task automatic chk(input bit ok, input string tag, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_lane(input logic [15:0] x, input logic [15:0] k);
        int e, ne;
        e = int'(x[14:7]);
        if (e == 255) return (x[6:0] != 0) ? (x | 16'h0040) : x;
        if (e == 0) return {x[15], 15'd0};
        ne = e + int'($signed(k));
        if (ne >= 255) return {x[15], 15'h7F80};
        if (ne <= 0) return {x[15], 15'd0};
        return {x[15], ne[7:0], x[6:0]};
    endfunction

    function automatic logic [15:0] lane(input int r, input int j);
        return rf[r][16*j +: 16];
    endfunction

    // reference monitor, every clock
    always @(negedge clk) begin
        bit dn;
        wr_t w;
        if (run_mon) begin
            dn = 0;
            if (done || dexp) chk(done == dexp, "R9 done timing", VLEN'(done), VLEN'(dexp));
            if (rf_wr_en) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R7 unexpected write", VLEN'(rf_wr_idx), '0);
                end else begin
                    w = exp_q.pop_front();
                    chk(int'(rf_wr_idx) == w.idx, "R3 R10 write index", VLEN'(rf_wr_idx), VLEN'(w.idx));
                    chk(rf_wr_data == w.data, "R1 R2 R6 write data", rf_wr_data, w.data);
                    if (exp_q.size() == 0) dn = 1;
                end
            end
            dexp = dn;
        end
    end

    task automatic issue(input bit quad, input logic [3:0] grp, input logic [3:0] sreg);
        int base, n;
        logic [VLEN-1:0] res;
        bit ok;
        while (!req_ready) @(negedge clk);
        ok = feat_a_en && feat_b_en;
        if (ok) begin
            base = quad ? int'(grp[2:0]) * 4 : int'(grp) * 2;
            n = quad ? 4 : 2;
            for (int r = 0; r < n; r++) begin
                for (int j = 0; j < LANES; j++)
                    res[16*j +: 16] = ref_lane(rf[base+r][16*j +: 16], rf[sreg][16*j +: 16]);
                exp_q.push_back('{base+r, res});
                shadow[base+r] = res;
            end
        end
        req_valid = 1; req_quad = quad; req_grp = grp; req_scl = sreg;
        @(negedge clk);
        req_valid = 0;
        chk(undef == !ok, "R8 undef pulse", VLEN'(undef), VLEN'(!ok));
        chk(req_ready == !ok, "R9 ready after accept", VLEN'(req_ready), VLEN'(!ok));
    endtask

    task automatic settle();
        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        logic [15:0] s5 [8] = '{16'h0001, 16'hFFFF, 16'h00C8, 16'hFF38, 16'h7FFF, 16'h8000, 16'h0003, 16'h0000};
        logic [15:0] r6 [8] = '{16'h3F80, 16'hC000, 16'h4000, 16'h3F80, 16'h7FA0, 16'h0005, 16'hFF80, 16'h8000};
        logic [15:0] r7 [8] = '{16'h4049, 16'h0080, 16'h7F00, 16'h0080, 16'h3F80, 16'hBF80, 16'h4040, 16'hFFC1};
        for (int i = 0; i < REGS; i++)
            for (int j = 0; j < LANES; j++)
                rf[i][16*j +: 16] = 16'(i * 16'h1357 + j * 16'h2468 + 16'h3C00);
        for (int j = 0; j < LANES; j++) begin
            rf[5][16*j +: 16] = s5[j];
            rf[6][16*j +: 16] = r6[j];
            rf[7][16*j +: 16] = r7[j];
            rf[15][16*j +: 16] = 16'(j - 4);
            rf[1][16*j +: 16] = 16'(j * 3 - 10);
            rf[9][16*j +: 16] = 16'(2 - j);
            rf[2][16*j +: 16] = 16'h0001;
            rf[3][16*j +: 16] = 16'h3F80;
        end
        for (int i = 0; i < REGS; i++) shadow[i] = rf[i];

        repeat (3) @(negedge clk);
        chk(req_ready == 1 && done == 0 && undef == 0 && rf_wr_en == 0, "R9 reset state",
            VLEN'({req_ready, done, undef, rf_wr_en}), VLEN'(4'b1000));
        rst_n = 1;
        @(negedge clk);
        run_mon = 1;

        // pair form, group field 3 -> regs 6,7, scale reg 5
        issue(0, 4'd3, 4'd5);
        settle();
        chk(lane(6, 0) == 16'h4000, "R1 scale by +1", VLEN'(lane(6, 0)), VLEN'(16'h4000));
        chk(lane(6, 1) == 16'hBF80, "R1 scale by -1", VLEN'(lane(6, 1)), VLEN'(16'hBF80));
        chk(lane(6, 2) == 16'h7F80, "R2 overflow to inf", VLEN'(lane(6, 2)), VLEN'(16'h7F80));
        chk(lane(7, 1) == 16'h0000, "R2 underflow to zero", VLEN'(lane(7, 1)), VLEN'(16'h0000));
        chk(lane(6, 5) == 16'h0000, "R2 subnormal flush", VLEN'(lane(6, 5)), VLEN'(16'h0000));
        chk(lane(7, 5) == 16'h8000, "R2 scale -32768", VLEN'(lane(7, 5)), VLEN'(16'h8000));
        chk(lane(7, 4) == 16'h7F80, "R2 scale 32767", VLEN'(lane(7, 4)), VLEN'(16'h7F80));
        chk(lane(6, 4) == 16'h7FE0, "R6 NaN quieted", VLEN'(lane(6, 4)), VLEN'(16'h7FE0));
        chk(lane(6, 6) == 16'hFF80, "R6 inf kept", VLEN'(lane(6, 6)), VLEN'(16'hFF80));
        chk(lane(7, 6) == 16'h41C0, "R1 scale by +3", VLEN'(lane(7, 6)), VLEN'(16'h41C0));
        chk(rf[5] == shadow[5], "R4 scale reg untouched", rf[5], shadow[5]);

        // quad form, field bit 3 set must be ignored -> regs 20..23, scale reg 15
        issue(1, 4'b1101, 4'd15);
        settle();
        chk(rf[24] == shadow[24] && rf[19] == shadow[19], "R3 quad bit3 ignored", rf[24], shadow[24]);

        // quad group 0..3 containing its own scale reg 2
        issue(1, 4'd0, 4'd2);
        settle();
        chk(lane(3, 0) == 16'h3F80 + 16'h0080, "R5 original scale used", VLEN'(lane(3, 0)), VLEN'(16'h4000));
        chk(lane(2, 0) == 16'h0000, "R5 scale reg in group rewritten", VLEN'(lane(2, 0)), '0);

        // feature disabled
        feat_b_en = 0;
        issue(0, 4'd2, 4'd1);
        settle();
        feat_b_en = 1;
        feat_a_en = 0;
        issue(1, 4'd1, 4'd1);
        settle();
        feat_a_en = 1;

        // back to back requests
        issue(0, 4'd12, 4'd1);
        issue(0, 4'd13, 4'd9);
        issue(1, 4'd7, 4'd15);
        settle();

        for (int i = 0; i < REGS; i++)
            chk(rf[i] == shadow[i], "R7 R8 final register file", rf[i], shadow[i]);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end
endmodule